// File: doc/BRIEF.md
# CAN Bit Timing Search Engine

This block works out the bit timing for a CAN node in hardware. Software or a sequencer supplies the reference clock frequency, the wanted bitrate and, if it has one, a wanted sample point in tenths of a percent. It also supplies the legal ranges and step for the prescaler and the legal ranges for the two time segments. After a one-cycle `start` pulse, the engine walks through the candidate bit lengths from the longest down to the shortest. It reports the chosen prescaler, the two segment lengths, a jump width of one quantum, the sample point achieved and the bitrate achieved. It raises a flag when the best rate it can reach is too far off, or when no prescaler fits.

All quotients come from one shared restoring divider that produces one quotient bit per cycle. A search therefore takes a few thousand cycles. `busy` is high for the whole search, and a single-cycle `done` marks the moment the outputs take their new values.

Top module: `can_bt_search`

## Requirements
- R1: When `sp_req` is 0, the target sample point is 750 for bitrates above 800000, 800 for bitrates above 500000, and 875 otherwise. A nonzero `sp_req` is used as given.
- R2: A candidate index k runs from 2*(t1_hi+t2_hi)+1 down to 2*(t1_lo+t2_lo). The segment sum is k/2 and the total quanta is k/2+1. The prescaler is ref_hz/(total*rate_req) plus 1 when k is odd. It is then rounded down to a multiple of `brp_step`, and skipped if it falls outside [brp_lo, brp_hi]. The reported prescaler always lies in that range and is a multiple of the step.
- R3: The rate error is |rate_req - ref_hz/(prescaler*total)|. A candidate with a larger error than the best so far is dropped. An equal error replaces the best, so later (shorter) candidates win ties.
- R4: When a candidate has zero rate error, the split works as follows. The engine sets tseg2 = sum+1-(sp*(sum+1))/1000 and clamps it to [t2_lo, t2_hi], then sets tseg1 = sum-tseg2. If tseg1 exceeds t1_hi, tseg1 becomes t1_hi and tseg2 becomes sum-tseg1. The reported segments come from the same rule applied to the winning sum.
- R5: The achieved sample point is 1000*(sum+1-tseg2)/(sum+1). A zero-rate-error candidate whose distance from the target is larger than the best distance so far is dropped. The search stops at the first candidate with zero rate error and zero sample point error.
- R6: If the best rate error is nonzero and error*1000/rate_req exceeds 50, `param_err` is 1. If no candidate passes the prescaler range, `param_err` is 1 and every result output is 0.
- R7: `sjw_o` is always 1. `rate_o` equals ref_hz/(brp_o*(tseg1_o+tseg2_o+1)).
- R8: `busy` is high from the cycle after an accepted `start` until `done`. `done` lasts one cycle. The result outputs change only in the cycle where `done` is high.
- R9: A `start` pulse while `busy` is high has no effect. The run finishes in the same number of cycles with the same results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a search (taken when idle) |
| ref_hz | input | CLK_W | Reference clock frequency in Hz |
| rate_req | input | CLK_W | Wanted bitrate in bit/s |
| sp_req | input | SP_W | Wanted sample point in tenths of a percent, 0 for default |
| brp_lo | input | BRP_W | Smallest legal prescaler |
| brp_hi | input | BRP_W | Largest legal prescaler |
| brp_step | input | BRP_W | Prescaler granularity |
| t1_lo | input | SEG_W | Smallest legal segment 1 |
| t1_hi | input | SEG_W | Largest legal segment 1 |
| t2_lo | input | SEG_W | Smallest legal segment 2 |
| t2_hi | input | SEG_W | Largest legal segment 2 |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion strobe |
| brp_o | output | BRP_W | Chosen prescaler |
| tseg1_o | output | SEG_W | Segment 1 in quanta |
| tseg2_o | output | SEG_W | Segment 2 in quanta |
| sjw_o | output | SJW_W | Jump width in quanta |
| sp_o | output | SP_W | Achieved sample point |
| rate_o | output | CLK_W | Achieved bitrate |
| param_err | output | 1 | Rate error too large or no legal prescaler |

## Verification
The properties assume that every configuration input stays unchanged from the accepted `start` until `done`. They also assume that `brp_step` and `brp_lo` are at least 1, that `rate_req` is nonzero, that each lower bound is no larger than its upper bound, and that any nonzero `sp_req` is at most 1000. The range and rate checks are meaningful only under these conditions. The driver applies a whole configuration before it pulses `start` and leaves it alone until the scoreboard has taken the result. Every configuration it uses satisfies these bounds, including the one with no legal prescaler and the one with a large rate error.

// File: rtl/can_bt_pkg.sv
// Shared constants and the controller state type for the bit timing search.
package can_bt_pkg;

    localparam int SP_SCALE       = 1000;    // sample point unit: tenths of a percent
    localparam int MAX_ERR_TENTHS = 50;      // largest tolerated rate error
    localparam int SPEED_FAST     = 800000;  // above this: fast default target
    localparam int SPEED_MID      = 500000;  // above this: middle default target
    localparam int SP_FAST        = 750;
    localparam int SP_MID         = 800;
    localparam int SP_SLOW        = 875;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CAND,
        ST_W_BRP,
        ST_W_INC,
        ST_CHECK,
        ST_W_RATE,
        ST_W_SPQ,
        ST_W_SPT,
        ST_NEXT,
        ST_FIN,
        ST_W_PCT,
        ST_F_SPQ,
        ST_W_FSPQ,
        ST_W_FSPT,
        ST_W_FRATE,
        ST_DONE
    } bt_state_t;

endpackage

// File: rtl/can_bt_div.sv
// Restoring unsigned divider that produces one quotient bit per cycle.
// Assumes: den is nonzero (a zero divisor yields an all-ones quotient).
// The quotient holds its value after done until the next go.
module can_bt_div #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem;
    logic [W-1:0]  q_sh;
    logic [W-1:0]  den_r;
    logic [CW-1:0] cnt;
    logic          active;
    logic [W:0]    shifted;
    logic [W:0]    trial;

    // Shift in the next dividend bit and try subtracting the divisor.
    always_comb begin
        shifted = {rem, q_sh[W-1]};
        trial   = shifted - {1'b0, den_r};
    end

    // Iterate one bit per cycle; strobe done after the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem    <= '0;
            q_sh   <= '0;
            den_r  <= '0;
            cnt    <= '0;
            active <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                rem    <= '0;
                q_sh   <= num;
                den_r  <= den;
                cnt    <= CW'(W);
                active <= 1'b1;
            end else if (active) begin
                if (!trial[W]) begin
                    rem  <= trial[W-1:0];
                    q_sh <= {q_sh[W-2:0], 1'b1};
                end else begin
                    rem  <= shifted[W-1:0];
                    q_sh <= {q_sh[W-2:0], 1'b0};
                end
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign quo = q_sh;

endmodule

// File: rtl/can_bt_sp_default.sv
// Picks the sample point target: the requested one if nonzero, otherwise
// a default chosen from the bitrate band.
module can_bt_sp_default #(
    parameter int CLK_W = 32,
    parameter int SP_W  = 10
) (
    input  logic [CLK_W-1:0] rate,
    input  logic [SP_W-1:0]  sp_req,
    output logic [SP_W-1:0]  sp_tgt
);
    import can_bt_pkg::*;

    localparam logic [CLK_W-1:0] LIM_FAST = CLK_W'(SPEED_FAST);
    localparam logic [CLK_W-1:0] LIM_MID  = CLK_W'(SPEED_MID);

    // Band selection with the explicit request taking precedence.
    always_comb begin
        if (sp_req != '0)
            sp_tgt = sp_req;
        else if (rate > LIM_FAST)
            sp_tgt = SP_W'(SP_FAST);
        else if (rate > LIM_MID)
            sp_tgt = SP_W'(SP_MID);
        else
            sp_tgt = SP_W'(SP_SLOW);
    end

endmodule

// File: rtl/can_bt_split.sv
// Splits a segment sum into segment 1 and segment 2 from the scaled
// sample point quotient q = sp*(sum+1)/1000, clamping to the legal limits.
// Assumes: q <= sum+1 and sum >= t2_min.
module can_bt_split #(
    parameter int SEG_W = 5
) (
    input  logic [SEG_W+1:0] seg,
    input  logic [SEG_W+1:0] q,
    input  logic [SEG_W-1:0] t1_max,
    input  logic [SEG_W-1:0] t2_min,
    input  logic [SEG_W-1:0] t2_max,
    output logic [SEG_W+1:0] t1,
    output logic [SEG_W+1:0] t2,
    output logic [SEG_W+1:0] lead
);
    localparam int SW = SEG_W + 2;
    localparam int IW = SEG_W + 4;

    logic signed [IW-1:0] s_seg, s_q, s_t1max, s_t2min, s_t2max;
    logic signed [IW-1:0] s_t1, s_t2;

    // Clamp segment 2 first, then give segment 1 priority on its ceiling.
    always_comb begin
        s_seg   = IW'(seg);
        s_q     = IW'(q);
        s_t1max = IW'(t1_max);
        s_t2min = IW'(t2_min);
        s_t2max = IW'(t2_max);
        s_t2    = s_seg + IW'(1) - s_q;
        if (s_t2 < s_t2min) s_t2 = s_t2min;
        if (s_t2 > s_t2max) s_t2 = s_t2max;
        s_t1 = s_seg - s_t2;
        if (s_t1 > s_t1max) begin
            s_t1 = s_t1max;
            s_t2 = s_seg - s_t1;
        end
        t1   = SW'(s_t1);
        t2   = SW'(s_t2);
        lead = SW'(s_seg + IW'(1) - s_t2);
    end

endmodule

// File: rtl/can_bt_search.sv
// Sequential search for a CAN prescaler and segment split.
// Walks candidate bit lengths downward, keeps the best rate match (ties go
// to the later candidate), refines zero-error matches by sample point
// distance, then derives the final split, sample point and bitrate.
// Assumes: configuration inputs stay steady while busy; brp_step >= 1,
// brp_lo >= 1, rate_req != 0, lower bounds <= upper bounds, sp_req <= 1000.
module can_bt_search #(
    parameter int CLK_W = 32,
    parameter int BRP_W = 11,
    parameter int SEG_W = 5,
    parameter int SP_W  = 10,
    parameter int SJW_W = 2,
    parameter int DIV_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CLK_W-1:0] ref_hz,
    input  logic [CLK_W-1:0] rate_req,
    input  logic [SP_W-1:0]  sp_req,
    input  logic [BRP_W-1:0] brp_lo,
    input  logic [BRP_W-1:0] brp_hi,
    input  logic [BRP_W-1:0] brp_step,
    input  logic [SEG_W-1:0] t1_lo,
    input  logic [SEG_W-1:0] t1_hi,
    input  logic [SEG_W-1:0] t2_lo,
    input  logic [SEG_W-1:0] t2_hi,
    output logic             busy,
    output logic             done,
    output logic [BRP_W-1:0] brp_o,
    output logic [SEG_W-1:0] tseg1_o,
    output logic [SEG_W-1:0] tseg2_o,
    output logic [SJW_W-1:0] sjw_o,
    output logic [SP_W-1:0]  sp_o,
    output logic [CLK_W-1:0] rate_o,
    output logic             param_err
);
    import can_bt_pkg::*;

    localparam int SW    = SEG_W + 2;   // segment sum / total quanta width
    localparam int IDX_W = SEG_W + 3;   // candidate index width
    localparam int EW    = CLK_W + 1;   // prescaler candidate / rate error width
    localparam int PW    = SP_W + 1;    // sample point error width

    bt_state_t        state;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_hi, idx_lo;
    logic [SW-1:0]    seg_cur, tot_cur, best_tot;
    logic [SP_W-1:0]  sp_tgt, sp_t;
    logic [EW-1:0]    cand_r, raw_cand, rate_err, best_err;
    logic [PW-1:0]    sp_err, spt_err;
    logic [SW-1:0]    best_seg;
    logic [BRP_W-1:0] cur_brp, best_brp;
    logic             found;
    logic [SW-1:0]    t1_r, t2_r;
    logic [SP_W-1:0]  sp_r;
    logic [CLK_W-1:0] rate_r;
    logic             err_r;

    logic             div_go, div_done;
    logic [DIV_W-1:0] div_num, div_den, div_quo;

    logic [SW-1:0]    split_seg, split_t1, split_t2, split_lead;

    // Index bounds and per-candidate quantities derived from the index.
    always_comb begin
        idx_hi   = ((IDX_W'(t1_hi) + IDX_W'(t2_hi)) << 1) | IDX_W'(1);
        idx_lo   = (IDX_W'(t1_lo) + IDX_W'(t2_lo)) << 1;
        seg_cur  = idx[IDX_W-1:1];
        tot_cur  = seg_cur + SW'(1);
        best_tot = best_seg + SW'(1);
        raw_cand = EW'(div_quo) + EW'(idx[0]);
        rate_err = (EW'(rate_req) >= EW'(div_quo)) ? EW'(rate_req) - EW'(div_quo)
                                                   : EW'(div_quo) - EW'(rate_req);
        sp_err   = (PW'(sp_t) >= PW'(div_quo)) ? PW'(sp_t) - PW'(div_quo)
                                               : PW'(div_quo) - PW'(sp_t);
        split_seg = (state == ST_W_FSPQ) ? best_seg : seg_cur;
    end

    can_bt_sp_default #(.CLK_W(CLK_W), .SP_W(SP_W)) u_spdef (
        .rate   (rate_req),
        .sp_req (sp_req),
        .sp_tgt (sp_tgt)
    );

    can_bt_split #(.SEG_W(SEG_W)) u_split (
        .seg    (split_seg),
        .q      (div_quo[SW-1:0]),
        .t1_max (t1_hi),
        .t2_min (t2_lo),
        .t2_max (t2_hi),
        .t1     (split_t1),
        .t2     (split_t2),
        .lead   (split_lead)
    );

    can_bt_div #(.W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    // Search controller: issues divisions, tracks the best candidate, publishes results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            idx       <= '0;
            sp_t      <= '0;
            cand_r    <= '0;
            best_err  <= '1;
            spt_err   <= '0;
            best_seg  <= '0;
            cur_brp   <= '0;
            best_brp  <= '0;
            found     <= 1'b0;
            t1_r      <= '0;
            t2_r      <= '0;
            sp_r      <= '0;
            rate_r    <= '0;
            err_r     <= 1'b0;
            div_go    <= 1'b0;
            div_num   <= '0;
            div_den   <= '0;
            done      <= 1'b0;
            brp_o     <= '0;
            tseg1_o   <= '0;
            tseg2_o   <= '0;
            sp_o      <= '0;
            rate_o    <= '0;
            param_err <= 1'b0;
        end else begin
            div_go <= 1'b0;
            done   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        sp_t     <= sp_tgt;
                        idx      <= idx_hi;
                        best_err <= '1;
                        spt_err  <= PW'(SP_SCALE);
                        found    <= 1'b0;
                        state    <= ST_CAND;
                    end
                end
                ST_CAND: begin
                    div_go  <= 1'b1;
                    div_num <= DIV_W'(ref_hz);
                    div_den <= DIV_W'(tot_cur) * DIV_W'(rate_req);
                    state   <= ST_W_BRP;
                end
                ST_W_BRP: begin
                    if (div_done) begin
                        if (brp_step == BRP_W'(1)) begin
                            cand_r <= raw_cand;
                            state  <= ST_CHECK;
                        end else begin
                            div_go  <= 1'b1;
                            div_num <= DIV_W'(raw_cand);
                            div_den <= DIV_W'(brp_step);
                            state   <= ST_W_INC;
                        end
                    end
                end
                ST_W_INC: begin
                    if (div_done) begin
                        cand_r <= EW'(div_quo) * EW'(brp_step);
                        state  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (cand_r < EW'(brp_lo) || cand_r > EW'(brp_hi)) begin
                        state <= ST_NEXT;
                    end else begin
                        cur_brp <= BRP_W'(cand_r);
                        div_go  <= 1'b1;
                        div_num <= DIV_W'(ref_hz);
                        div_den <= DIV_W'(cand_r) * DIV_W'(tot_cur);
                        state   <= ST_W_RATE;
                    end
                end
                ST_W_RATE: begin
                    if (div_done) begin
                        if (rate_err > best_err) begin
                            state <= ST_NEXT;
                        end else begin
                            best_err <= rate_err;
                            if (rate_err != '0) begin
                                best_seg <= seg_cur;
                                best_brp <= cur_brp;
                                found    <= 1'b1;
                                state    <= ST_NEXT;
                            end else begin
                                div_go  <= 1'b1;
                                div_num <= DIV_W'(sp_t) * DIV_W'(tot_cur);
                                div_den <= DIV_W'(SP_SCALE);
                                state   <= ST_W_SPQ;
                            end
                        end
                    end
                end
                ST_W_SPQ: begin
                    if (div_done) begin
                        div_go  <= 1'b1;
                        div_num <= DIV_W'(SP_SCALE) * DIV_W'(split_lead);
                        div_den <= DIV_W'(tot_cur);
                        state   <= ST_W_SPT;
                    end
                end
                ST_W_SPT: begin
                    if (div_done) begin
                        if (sp_err > spt_err) begin
                            state <= ST_NEXT;
                        end else begin
                            spt_err  <= sp_err;
                            best_seg <= seg_cur;
                            best_brp <= cur_brp;
                            found    <= 1'b1;
                            state    <= (sp_err == '0) ? ST_FIN : ST_NEXT;
                        end
                    end
                end
                ST_NEXT: begin
                    if (idx == idx_lo) begin
                        state <= ST_FIN;
                    end else begin
                        idx   <= idx - IDX_W'(1);
                        state <= ST_CAND;
                    end
                end
                ST_FIN: begin
                    if (!found) begin
                        best_brp <= '0;
                        t1_r     <= '0;
                        t2_r     <= '0;
                        sp_r     <= '0;
                        rate_r   <= '0;
                        err_r    <= 1'b1;
                        state    <= ST_DONE;
                    end else if (best_err != '0) begin
                        div_go  <= 1'b1;
                        div_num <= DIV_W'(best_err) * DIV_W'(SP_SCALE);
                        div_den <= DIV_W'(rate_req);
                        state   <= ST_W_PCT;
                    end else begin
                        err_r <= 1'b0;
                        state <= ST_F_SPQ;
                    end
                end
                ST_W_PCT: begin
                    if (div_done) begin
                        err_r <= (div_quo > DIV_W'(MAX_ERR_TENTHS));
                        state <= ST_F_SPQ;
                    end
                end
                ST_F_SPQ: begin
                    div_go  <= 1'b1;
                    div_num <= DIV_W'(sp_t) * DIV_W'(best_tot);
                    div_den <= DIV_W'(SP_SCALE);
                    state   <= ST_W_FSPQ;
                end
                ST_W_FSPQ: begin
                    if (div_done) begin
                        t1_r    <= split_t1;
                        t2_r    <= split_t2;
                        div_go  <= 1'b1;
                        div_num <= DIV_W'(SP_SCALE) * DIV_W'(split_lead);
                        div_den <= DIV_W'(best_tot);
                        state   <= ST_W_FSPT;
                    end
                end
                ST_W_FSPT: begin
                    if (div_done) begin
                        sp_r    <= SP_W'(div_quo);
                        div_go  <= 1'b1;
                        div_num <= DIV_W'(ref_hz);
                        div_den <= DIV_W'(best_brp) * DIV_W'(best_tot);
                        state   <= ST_W_FRATE;
                    end
                end
                ST_W_FRATE: begin
                    if (div_done) begin
                        rate_r <= CLK_W'(div_quo);
                        state  <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    brp_o     <= best_brp;
                    tseg1_o   <= SEG_W'(t1_r);
                    tseg2_o   <= SEG_W'(t2_r);
                    sp_o      <= sp_r;
                    rate_o    <= rate_r;
                    param_err <= err_r;
                    done      <= 1'b1;
                    state     <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy  = (state != ST_IDLE);
    assign sjw_o = SJW_W'(1);

endmodule

// File: rtl/can_bt_search_chk.sv
// Property checker for can_bt_search, attached by bind below.
// Assumes configuration inputs are steady from start to done.
module can_bt_search_chk #(
    parameter int CLK_W = 32,
    parameter int BRP_W = 11,
    parameter int SEG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [CLK_W-1:0] ref_hz,
    input logic [BRP_W-1:0] brp_lo,
    input logic [BRP_W-1:0] brp_hi,
    input logic [BRP_W-1:0] brp_step,
    input logic [SEG_W-1:0] t1_hi,
    input logic [SEG_W-1:0] t2_lo,
    input logic [SEG_W-1:0] t2_hi,
    input logic [BRP_W-1:0] brp_o,
    input logic [SEG_W-1:0] tseg1_o,
    input logic [SEG_W-1:0] tseg2_o,
    input logic [CLK_W-1:0] rate_o,
    input logic             param_err
);

    // R8: the completion strobe is a single cycle wide
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: results move only together with the strobe
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(brp_o) && $stable(tseg1_o) && $stable(tseg2_o)
                   && $stable(rate_o) && $stable(param_err)));

    // R8: a strobe ends a busy period and leaves the engine idle
    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R8: an accepted start makes the engine busy on the next cycle
    assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R2: reported prescaler is legal
    assert_brp_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !param_err) |-> (brp_o >= brp_lo && brp_o <= brp_hi
                                  && (brp_o % brp_step) == '0));

    // R4: reported segments respect their limits
    assert_seg_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !param_err) |-> (tseg2_o >= t2_lo && tseg2_o <= t2_hi
                                  && tseg1_o <= t1_hi));

    // R7: reported bitrate agrees with the reported timing
    assert_rate_match_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !param_err) |-> (64'(rate_o) == 64'(ref_hz) /
            (64'(brp_o) * (64'(tseg1_o) + 64'(tseg2_o) + 64'd1))));

endmodule

bind can_bt_search can_bt_search_chk #(
    .CLK_W(CLK_W), .BRP_W(BRP_W), .SEG_W(SEG_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .ref_hz(ref_hz), .brp_lo(brp_lo), .brp_hi(brp_hi), .brp_step(brp_step),
    .t1_hi(t1_hi), .t2_lo(t2_lo), .t2_hi(t2_hi), .brp_o(brp_o),
    .tseg1_o(tseg1_o), .tseg2_o(tseg2_o), .rate_o(rate_o), .param_err(param_err)
);

// File: tb/can_bt_search_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues model results, the monitor compares at done.
module can_bt_search_test;

    typedef struct {
        longint refhz, rate, sp, bmin, bmax, bstep, t1min, t1max, t2min, t2max;
    } cfg_t;

    typedef struct {
        longint brp, t1, t2, sp, rate, err;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ref_hz = '0, rate_req = '0;
    logic [9:0]  sp_req = '0;
    logic [10:0] brp_lo = '0, brp_hi = '0, brp_step = '0;
    logic [4:0]  t1_lo = '0, t1_hi = '0, t2_lo = '0, t2_hi = '0;
    logic        busy, done, param_err;
    logic [10:0] brp_o;
    logic [4:0]  tseg1_o, tseg2_o;
    logic [1:0]  sjw_o;
    logic [9:0]  sp_o;
    logic [31:0] rate_o;

    int     total = 0;
    int     bad = 0;
    longint cyc = 0;
    exp_t   exp_q[$];
    bit     moved = 1'b0;
    bit     finished = 1'b0;

    always #2.5 clk = ~clk;

    can_bt_search uut (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_hz(ref_hz), .rate_req(rate_req),
        .sp_req(sp_req), .brp_lo(brp_lo), .brp_hi(brp_hi), .brp_step(brp_step),
        .t1_lo(t1_lo), .t1_hi(t1_hi), .t2_lo(t2_lo), .t2_hi(t2_hi), .busy(busy),
        .done(done), .brp_o(brp_o), .tseg1_o(tseg1_o), .tseg2_o(tseg2_o),
        .sjw_o(sjw_o), .sp_o(sp_o), .rate_o(rate_o), .param_err(param_err)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input longint act, input longint expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic void split(input longint seg, input longint sp, input cfg_t c,
                                  output longint t1, output longint t2);
        t2 = seg + 1 - (sp * (seg + 1)) / 1000;
        if (t2 < c.t2min) t2 = c.t2min;
        if (t2 > c.t2max) t2 = c.t2max;
        t1 = seg - t2;
        if (t1 > c.t1max) begin
            t1 = c.t1max;
            t2 = seg - t1;
        end
    endfunction

    // Reference model written from the requirements.
    function automatic exp_t model(input cfg_t c);
        exp_t   r;
        longint sp, best_err, spt_err, best_seg, best_brp, t1, t2;
        bit     found, stop;
        if (c.sp != 0)          sp = c.sp;
        else if (c.rate > 800000) sp = 750;
        else if (c.rate > 500000) sp = 800;
        else                    sp = 875;
        best_err = 64'h7fff_ffff_ffff_ffff;
        spt_err = 1000; best_seg = 0; best_brp = 0; found = 0; stop = 0;
        for (longint idx = 2 * (c.t1max + c.t2max) + 1;
             idx >= 2 * (c.t1min + c.t2min) && !stop; idx--) begin
            longint seg = idx / 2;
            longint tot = seg + 1;
            longint brp = c.refhz / (tot * c.rate) + idx % 2;
            longint rt, err;
            brp = (brp / c.bstep) * c.bstep;
            if (brp < c.bmin || brp > c.bmax) continue;
            rt = c.refhz / (brp * tot);
            err = c.rate - rt;
            if (err < 0) err = -err;
            if (err > best_err) continue;
            best_err = err;
            if (err == 0) begin
                longint spt, e;
                split(seg, sp, c, t1, t2);
                spt = 1000 * (seg + 1 - t2) / (seg + 1);
                e = sp - spt;
                if (e < 0) e = -e;
                if (e > spt_err) continue;
                spt_err = e;
                if (e == 0) stop = 1;
            end
            best_seg = seg; best_brp = brp; found = 1;
        end
        if (!found) begin
            r = '{0, 0, 0, 0, 0, 1};
        end else begin
            split(best_seg, sp, c, t1, t2);
            r.brp  = best_brp;
            r.t1   = t1;
            r.t2   = t2;
            r.sp   = 1000 * (best_seg + 1 - t2) / (best_seg + 1);
            r.rate = c.refhz / (best_brp * (best_seg + 1));
            r.err  = (best_err != 0 && (best_err * 1000) / c.rate > 50) ? 1 : 0;
        end
        return r;
    endfunction

    function automatic cfg_t mk(input longint refhz, input longint rate, input longint sp);
        cfg_t c;
        c = '{refhz, rate, sp, 1, 1024, 1, 1, 16, 1, 8};
        return c;
    endfunction

    // Driver: apply config, queue expectation, pulse start, optionally poke start mid-run.
    task automatic run_case(input cfg_t c, input int poke, output longint dur);
        longint t0;
        ref_hz = 32'(c.refhz); rate_req = 32'(c.rate); sp_req = 10'(c.sp);
        brp_lo = 11'(c.bmin); brp_hi = 11'(c.bmax); brp_step = 11'(c.bstep);
        t1_lo = 5'(c.t1min); t1_hi = 5'(c.t1max); t2_lo = 5'(c.t2min); t2_hi = 5'(c.t2max);
        exp_q.push_back(model(c));
        @(negedge clk);
        start = 1'b1;
        t0 = cyc;
        @(negedge clk);
        start = 1'b0;
        if (poke > 0) begin
            repeat (poke) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        dur = cyc - t0;
        @(negedge clk);
    endtask

    // Monitor: compare results at done, watch for output motion otherwise.
    initial begin
        logic [63:0] prev_snap;
        bit          prev_done;
        prev_snap = '0;
        prev_done = 1'b0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_done) chk("R8 done width", done, 0);
                if (done) begin
                    if (exp_q.size() == 0) begin
                        chk("R9 unexpected done", 1, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk("R2 R3 prescaler", brp_o, e.brp);
                        chk("R4 tseg1", tseg1_o, e.t1);
                        chk("R4 tseg2", tseg2_o, e.t2);
                        chk("R1 R5 sample point", sp_o, e.sp);
                        chk("R7 bitrate", rate_o, e.rate);
                        chk("R7 sjw", sjw_o, 1);
                        chk("R6 error flag", param_err, e.err);
                    end
                    chk("R8 outputs held while busy", moved, 0);
                    moved = 1'b0;
                end else if ({brp_o, tseg1_o, tseg2_o, sp_o, rate_o, param_err} != 64'(prev_snap)) begin
                    moved = 1'b1;
                end
                prev_snap = 64'({brp_o, tseg1_o, tseg2_o, sp_o, rate_o, param_err});
                prev_done = done;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        while (!finished && cyc < 190000) @(negedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        longint d1, d2, dx;
        cfg_t   c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset busy", busy, 0);
        chk("R8 reset done", done, 0);
        chk("R2 reset prescaler", brp_o, 0);
        chk("R6 reset flag", param_err, 0);
        chk("R7 reset sjw", sjw_o, 1);

        run_case(mk(36000000, 1000000, 0), 0, d1);   // R1 fast band
        run_case(mk(36000000, 800000, 0), 0, dx);    // R1 middle band
        run_case(mk(36000000, 500000, 0), 0, dx);    // R1 slow band boundary
        run_case(mk(36000000, 125000, 0), 0, dx);
        run_case(mk(36000000, 500000, 700), 0, dx);  // R1 explicit target
        run_case(mk(36000000, 83333, 0), 0, dx);     // R3 nonzero error, ties
        c = mk(36000000, 250000, 0);
        c.bstep = 4;                                 // R2 step truncation
        run_case(c, 0, dx);
        c = mk(36000000, 1000000, 0);
        c.bmin = 1000;                               // R6 no legal prescaler
        run_case(c, 0, dx);
        c = '{10000000, 3000000, 0, 1, 1024, 1, 1, 4, 1, 2};  // R6 large rate error
        run_case(c, 0, dx);
        run_case(mk(36000000, 1000000, 0), 40, d2);  // R9 start while busy
        chk("R9 run length with stray start", d2, d1);
        chk("R9 queue drained", exp_q.size(), 0);
        repeat (3) @(negedge clk);
        chk("R9 idle after run", busy, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule